// File: doc/BRIEF.md
# Branch Linkage and Addressing-Mode Unit

This block executes the subroutine call and return branches of a 32-bit register machine that runs in a 24-bit or a 31-bit addressing mode. For each issued operation it receives a decoded opcode, two register specifiers with their values, an effective address, the updated instruction address, the current mode, the condition code and the program mask. It returns the value and enable for the link register, the branch target, a taken flag and the mode that follows. It also trims a supplied effective address to the width of the current mode.

Bit 31 in this project is the most significant bit of a register. It is the bit that carries the mode in saved link words and in branch targets. Results are registered and appear one cycle after the operation is accepted.

Top module: `branch_link_unit`

## Requirements
- R1: In 24-bit mode (mode 0), every address the block emits (effective-address output, branch target) has bits 31:24 zero and bits 23:0 copied from the source.
- R2: In 31-bit mode (mode 1), every address the block emits has bit 31 zero and bits 30:0 copied from the source.
- R3: In mode 0, BAL and BALR write the link word {ilc[1:0], cc[1:0], pmask[3:0], ia[23:0]}. The ilc is 00 for BALR and 01 for BAL, so bit 31 is always 0.
- R4: In mode 1, BAL, BALR, BAS, BASR and BASSM write the link word {1'b1, ia[30:0]}.
- R5: In mode 0, BAS, BASR and BASSM write the link word {8'h00, ia[23:0]}.
- R6: BASSM and BSM with a nonzero second specifier take the branch. The next mode is bit 31 of the second register value, and the target is that value trimmed to the new mode.
- R7: BSM with first specifier 0 writes no link. With a nonzero first specifier it writes that register's value with only bit 31 replaced by the current mode.
- R8: For BALR, BASR, BASSM and BSM, a second specifier of 0 means no branch and an unchanged mode. The link defined by the opcode is still written.
- R9: BAL and BAS always branch to the effective address trimmed to the current mode. BAL, BALR, BAS and BASR never change the mode.
- R10: Opcode codes are 0 BAL, 1 BALR, 2 BAS, 3 BASR, 4 BASSM, 5 BSM. Codes 6 and 7 write no link and take no branch. Results and out_valid appear on the clock edge after the one that samples in_valid high, and the link index equals the first specifier.
- R11: While reset is asserted and before the first accepted operation, out_valid, link_we and br_taken are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Decoded opcode |
| r1_idx | input | 4 | First register specifier |
| r1_val | input | 32 | First register value |
| r2_idx | input | 4 | Second register specifier |
| r2_val | input | 32 | Second register value |
| ea_in | input | 32 | Effective address (target of BAL/BAS) |
| ia_next | input | 32 | Updated instruction address |
| amode | input | 1 | Current mode: 0 = 24-bit, 1 = 31-bit |
| cc | input | 2 | Condition code |
| pmask | input | 4 | Program mask |
| out_valid | output | 1 | Results valid |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 4 | Link register index |
| link_val | output | 32 | Link register value |
| br_taken | output | 1 | Branch taken |
| br_target | output | 32 | Branch target |
| amode_next | output | 1 | Mode after the operation |
| ea_out | output | 32 | Effective address trimmed to current mode |

## Verification
The hardest situation to reach from the ports is a round trip in which a return branch consumes a link word that the block itself produced. Only then can the mode restore of all four caller/callee pairs be judged. The stimulus chains each call's expected link word into the second register of the following BSM, run in the callee's mode. Every mode pairing is covered this way, next to the zero-specifier cases that suppress the branch but keep the link.

// File: rtl/blu_pkg.sv
package blu_pkg;
  typedef enum logic [2:0] {
    OP_BAL   = 3'd0,
    OP_BALR  = 3'd1,
    OP_BAS   = 3'd2,
    OP_BASR  = 3'd3,
    OP_BASSM = 3'd4,
    OP_BSM   = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } blu_op_e;

  localparam logic [1:0] ILC_RR = 2'b00;
  localparam logic [1:0] ILC_RX = 2'b01;
endpackage

// File: rtl/blu_rst_sync.sv
module blu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/blu_addr_mask.sv
module blu_addr_mask #(
  parameter int XLEN     = 32,
  parameter int NARROW_W = 24
) (
  input  logic            wide,
  input  logic [XLEN-1:0] addr,
  output logic [XLEN-1:0] masked
);
  localparam int HI_W = XLEN - NARROW_W;

  always_comb begin
    if (wide) masked = {1'b0, addr[XLEN-2:0]};
    else      masked = {{HI_W{1'b0}}, addr[NARROW_W-1:0]};
  end
endmodule

// File: rtl/blu_link_gen.sv
module blu_link_gen
  import blu_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NARROW_W = 24
) (
  input  blu_op_e         op,
  input  logic            amode,
  input  logic            r1_nz,
  input  logic [XLEN-1:0] r1_val,
  input  logic [XLEN-1:0] ia,
  input  logic [1:0]      cc,
  input  logic [3:0]      pmask,
  output logic            we,
  output logic [XLEN-1:0] link
);
  localparam int HI_W = XLEN - NARROW_W;

  logic [XLEN-1:0] wide_link;
  logic [XLEN-1:0] plain_narrow;
  logic [HI_W-1:0] status_byte;

  assign wide_link    = {1'b1, ia[XLEN-2:0]};
  assign plain_narrow = {{HI_W{1'b0}}, ia[NARROW_W-1:0]};

  always_comb begin
    status_byte = '0;
    status_byte[HI_W-1 -: 8] = {(op == OP_BAL) ? ILC_RX : ILC_RR, cc, pmask};
  end

  always_comb begin
    we   = 1'b0;
    link = '0;
    unique case (op)
      OP_BAL, OP_BALR: begin
        we   = 1'b1;
        link = amode ? wide_link : {status_byte, ia[NARROW_W-1:0]};
      end
      OP_BAS, OP_BASR, OP_BASSM: begin
        we   = 1'b1;
        link = amode ? wide_link : plain_narrow;
      end
      OP_BSM: begin
        we   = r1_nz;
        link = {amode, r1_val[XLEN-2:0]};
      end
      default: begin
        we   = 1'b0;
        link = '0;
      end
    endcase
  end
endmodule

// File: rtl/blu_branch_sel.sv
module blu_branch_sel
  import blu_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NARROW_W = 24
) (
  input  blu_op_e         op,
  input  logic            amode,
  input  logic            r2_nz,
  input  logic [XLEN-1:0] r2_val,
  input  logic [XLEN-1:0] ea,
  output logic            taken,
  output logic [XLEN-1:0] target,
  output logic            mode_next
);
  logic            switches;
  logic            tgt_mode;
  logic [XLEN-1:0] ea_m;
  logic [XLEN-1:0] reg_m;

  assign switches = (op == OP_BASSM) || (op == OP_BSM);
  assign tgt_mode = switches ? r2_val[XLEN-1] : amode;

  blu_addr_mask #(.XLEN(XLEN), .NARROW_W(NARROW_W)) u_mask_ea (
    .wide(amode), .addr(ea), .masked(ea_m)
  );
  blu_addr_mask #(.XLEN(XLEN), .NARROW_W(NARROW_W)) u_mask_reg (
    .wide(tgt_mode), .addr(r2_val), .masked(reg_m)
  );

  always_comb begin
    taken     = 1'b0;
    target    = '0;
    mode_next = amode;
    unique case (op)
      OP_BAL, OP_BAS: begin
        taken  = 1'b1;
        target = ea_m;
      end
      OP_BALR, OP_BASR: begin
        taken  = r2_nz;
        target = reg_m;
      end
      OP_BASSM, OP_BSM: begin
        taken     = r2_nz;
        target    = reg_m;
        mode_next = r2_nz ? tgt_mode : amode;
      end
      default: begin
        taken  = 1'b0;
        target = '0;
      end
    endcase
  end
endmodule

// File: rtl/branch_link_unit.sv
module branch_link_unit
  import blu_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NARROW_W = 24,
  parameter int RIDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [RIDX_W-1:0] r1_idx,
  input  logic [XLEN-1:0]   r1_val,
  input  logic [RIDX_W-1:0] r2_idx,
  input  logic [XLEN-1:0]   r2_val,
  input  logic [XLEN-1:0]   ea_in,
  input  logic [XLEN-1:0]   ia_next,
  input  logic              amode,
  input  logic [1:0]        cc,
  input  logic [3:0]        pmask,
  output logic              out_valid,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [XLEN-1:0]   link_val,
  output logic              br_taken,
  output logic [XLEN-1:0]   br_target,
  output logic              amode_next,
  output logic [XLEN-1:0]   ea_out
);
  localparam int HI_W = XLEN - NARROW_W;

  logic            rst_ns;
  blu_op_e         op_e;
  logic            lg_we, bs_taken, bs_mode;
  logic [XLEN-1:0] lg_link, bs_target, ea_m;

  assign op_e = blu_op_e'(op);

  blu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns)
  );

  blu_link_gen #(.XLEN(XLEN), .NARROW_W(NARROW_W)) u_link (
    .op(op_e), .amode(amode), .r1_nz(r1_idx != '0), .r1_val(r1_val),
    .ia(ia_next), .cc(cc), .pmask(pmask), .we(lg_we), .link(lg_link)
  );

  blu_branch_sel #(.XLEN(XLEN), .NARROW_W(NARROW_W)) u_br (
    .op(op_e), .amode(amode), .r2_nz(r2_idx != '0), .r2_val(r2_val),
    .ea(ea_in), .taken(bs_taken), .target(bs_target), .mode_next(bs_mode)
  );

  blu_addr_mask #(.XLEN(XLEN), .NARROW_W(NARROW_W)) u_mask_out (
    .wide(amode), .addr(ea_in), .masked(ea_m)
  );

  // next-state
  logic              vld_d, we_d, tk_d, md_d, mdcur_d;
  logic [RIDX_W-1:0] idx_d;
  logic [XLEN-1:0]   lnk_d, tgt_d, ea_d;
  blu_op_e           op_d;
  logic              data_en;

  // registers
  logic              vld_q, we_q, tk_q, md_q, mdcur_q;
  logic [RIDX_W-1:0] idx_q;
  logic [XLEN-1:0]   lnk_q, tgt_q, ea_q;
  blu_op_e           op_q;

  always_comb begin
    data_en = in_valid;
    vld_d   = in_valid;
    we_d    = in_valid & lg_we;
    tk_d    = in_valid & bs_taken;
    md_d    = bs_mode;
    mdcur_d = amode;
    idx_d   = r1_idx;
    lnk_d   = lg_link;
    tgt_d   = bs_target;
    ea_d    = ea_m;
    op_d    = op_e;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      vld_q <= 1'b0;
      we_q  <= 1'b0;
      tk_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      we_q  <= we_d;
      tk_q  <= tk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      md_q    <= 1'b0;
      mdcur_q <= 1'b0;
      idx_q   <= '0;
      lnk_q   <= '0;
      tgt_q   <= '0;
      ea_q    <= '0;
      op_q    <= OP_RSV7;
    end else if (data_en) begin
      md_q    <= md_d;
      mdcur_q <= mdcur_d;
      idx_q   <= idx_d;
      lnk_q   <= lnk_d;
      tgt_q   <= tgt_d;
      ea_q    <= ea_d;
      op_q    <= op_d;
    end
  end

  assign out_valid  = vld_q;
  assign link_we    = we_q;
  assign link_idx   = idx_q;
  assign link_val   = lnk_q;
  assign br_taken   = tk_q;
  assign br_target  = tgt_q;
  assign amode_next = md_q;
  assign ea_out     = ea_q;

  // R11: nothing issued without a valid result
  assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    !out_valid |-> (!link_we && !br_taken));

  // R1: narrow target has clear top byte
  assert_narrow_target_R1: assert property (@(posedge clk) disable iff (!rst_ns)
    (out_valid && br_taken && !amode_next) |-> (br_target[XLEN-1 -: HI_W] == '0));

  // R2: wide target has clear top bit
  assert_wide_target_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (out_valid && br_taken && amode_next) |-> !br_target[XLEN-1]);

  // R3: old-style link in narrow mode never carries a set top bit
  assert_bal_top_clear_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    (out_valid && link_we && !mdcur_q && (op_q == OP_BAL || op_q == OP_BALR))
      |-> !link_val[XLEN-1]);

  // R4: wide-mode call links carry the mode flag
  assert_wide_link_flag_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    (out_valid && link_we && mdcur_q && op_q != OP_BSM) |-> link_val[XLEN-1]);

  // R9: only the mode-setting branches may change the mode
  assert_mode_only_by_set_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    (out_valid && (amode_next != mdcur_q)) |-> (op_q == OP_BASSM || op_q == OP_BSM));

  // R8: no branch leaves the mode alone
  assert_nobranch_mode_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    (out_valid && !br_taken) |-> (amode_next == mdcur_q));

  // R10: a result follows every accepted operation on the next edge
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    in_valid |=> out_valid);
endmodule

// File: tb/tb_branch_link_unit.sv
module tb_branch_link_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic [3:0]  r1_idx, r2_idx;
  logic [31:0] r1_val, r2_val, ea_in, ia_next;
  logic        amode;
  logic [1:0]  cc;
  logic [3:0]  pmask;
  logic        out_valid, link_we, br_taken, amode_next;
  logic [3:0]  link_idx;
  logic [31:0] link_val, br_target, ea_out;

  always #10 clk = ~clk;

  branch_link_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .r1_idx(r1_idx), .r1_val(r1_val), .r2_idx(r2_idx), .r2_val(r2_val),
    .ea_in(ea_in), .ia_next(ia_next), .amode(amode), .cc(cc), .pmask(pmask),
    .out_valid(out_valid), .link_we(link_we), .link_idx(link_idx),
    .link_val(link_val), .br_taken(br_taken), .br_target(br_target),
    .amode_next(amode_next), .ea_out(ea_out)
  );

  typedef struct packed {
    logic        we;
    logic [3:0]  idx;
    logic [31:0] link;
    logic        taken;
    logic [31:0] target;
    logic        mode;
    logic [31:0] ea;
  } exp_t;

  exp_t   sb[$];
  string  tag_q[$];
  int     n_run = 0, n_fail = 0;
  bit     done = 1'b0;
  logic [31:0] last_link;

  function automatic logic [31:0] trim(input logic [31:0] a, input logic m);
    return m ? {1'b0, a[30:0]} : {8'h00, a[23:0]};
  endfunction

  // expected results straight from R1..R10
  function automatic exp_t predict(input logic [2:0] o, input logic [3:0] i1,
      input logic [31:0] v1, input logic [3:0] i2, input logic [31:0] v2,
      input logic [31:0] ea, input logic [31:0] ia, input logic m,
      input logic [1:0] c, input logic [3:0] p);
    exp_t e;
    e = '0;
    e.idx = i1; e.mode = m; e.ea = trim(ea, m);
    case (o)
      3'd0: begin e.we = 1; e.link = m ? {1'b1, ia[30:0]} : {2'b01, c, p, ia[23:0]};
                  e.taken = 1; e.target = trim(ea, m); end
      3'd1: begin e.we = 1; e.link = m ? {1'b1, ia[30:0]} : {2'b00, c, p, ia[23:0]};
                  e.taken = (i2 != 0); e.target = trim(v2, m); end
      3'd2: begin e.we = 1; e.link = m ? {1'b1, ia[30:0]} : {8'h00, ia[23:0]};
                  e.taken = 1; e.target = trim(ea, m); end
      3'd3: begin e.we = 1; e.link = m ? {1'b1, ia[30:0]} : {8'h00, ia[23:0]};
                  e.taken = (i2 != 0); e.target = trim(v2, m); end
      3'd4: begin e.we = 1; e.link = m ? {1'b1, ia[30:0]} : {8'h00, ia[23:0]};
                  e.taken = (i2 != 0); e.target = trim(v2, v2[31]);
                  if (i2 != 0) e.mode = v2[31]; end
      3'd5: begin e.we = (i1 != 0); e.link = {m, v1[30:0]};
                  e.taken = (i2 != 0); e.target = trim(v2, v2[31]);
                  if (i2 != 0) e.mode = v2[31]; end
      default: ;
    endcase
    return e;
  endfunction

  task automatic issue(input string tag, input logic [2:0] o, input logic [3:0] i1,
      input logic [31:0] v1, input logic [3:0] i2, input logic [31:0] v2,
      input logic [31:0] ea, input logic [31:0] ia, input logic m,
      input logic [1:0] c, input logic [3:0] p);
    exp_t e;
    e = predict(o, i1, v1, i2, v2, ea, ia, m, c, p);
    last_link = e.link;
    in_valid = 1; op = o; r1_idx = i1; r1_val = v1; r2_idx = i2; r2_val = v2;
    ea_in = ea; ia_next = ia; amode = m; cc = c; pmask = p;
    sb.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: pop and compare at the falling edge after capture
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (sb.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R10 unexpected result: out_valid=1 expected none");
      end else begin
        exp_t e;
        string t;
        logic ok;
        e = sb.pop_front(); t = tag_q.pop_front();
        ok = (link_we == e.we) && (br_taken == e.taken) && (amode_next == e.mode)
          && (ea_out == e.ea) && (!e.we || (link_val == e.link && link_idx == e.idx))
          && (!e.taken || br_target == e.target);
        n_run++;
        if (!ok) begin
          n_fail++;
          $display("FAIL %s: act we=%0b idx=%0d link=%h tk=%0b tgt=%h md=%0b ea=%h exp we=%0b idx=%0d link=%h tk=%0b tgt=%h md=%0b ea=%h",
            t, link_we, link_idx, link_val, br_taken, br_target, amode_next, ea_out,
            e.we, e.idx, e.link, e.taken, e.target, e.mode, e.ea);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; op = 0; r1_idx = 0; r1_val = 0; r2_idx = 0; r2_val = 0;
    ea_in = 0; ia_next = 0; amode = 0; cc = 0; pmask = 0;
    repeat (3) @(negedge clk);
    n_run++;
    if (out_valid || link_we || br_taken) begin
      n_fail++;
      $display("FAIL R11 reset: act v=%0b we=%0b tk=%0b exp 0 0 0", out_valid, link_we, br_taken);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
    n_run++;
    if (out_valid || link_we || br_taken) begin
      n_fail++;
      $display("FAIL R11 idle: act v=%0b we=%0b tk=%0b exp 0 0 0", out_valid, link_we, br_taken);
    end

    // R3 R1 R9: BAL/BALR narrow with status byte
    issue("R3 BAL narrow", 3'd0, 4'd14, 32'h0, 4'd0, 32'h0, 32'hFF12_3456, 32'hAB00_1004, 1'b0, 2'b10, 4'hC);
    issue("R3 BALR narrow", 3'd1, 4'd14, 32'h0, 4'd15, 32'hDE65_4320, 32'h0, 32'h7F00_2002, 1'b0, 2'b11, 4'h5);
    // R4 R2: wide links
    issue("R4 BAL wide", 3'd0, 4'd14, 32'h0, 4'd0, 32'h0, 32'hFFFF_FFFE, 32'hC000_1004, 1'b1, 2'b01, 4'hF);
    issue("R4 BALR wide", 3'd1, 4'd3, 32'h0, 4'd7, 32'h9234_5678, 32'h0, 32'h0123_4562, 1'b1, 2'b00, 4'h0);
    issue("R4 BAS wide", 3'd2, 4'd14, 32'h0, 4'd0, 32'h0, 32'h8000_0100, 32'h4000_0008, 1'b1, 2'b11, 4'h1);
    issue("R4 BASR wide", 3'd3, 4'd14, 32'h0, 4'd15, 32'hFFFF_FFFF, 32'h0, 32'h8000_0002, 1'b1, 2'b10, 4'h2);
    // R5 R1: narrow plain links
    issue("R5 BAS narrow", 3'd2, 4'd14, 32'h0, 4'd0, 32'h0, 32'h12FF_FFFF, 32'hFFAB_CDEF, 1'b0, 2'b11, 4'hF);
    issue("R5 BASR narrow", 3'd3, 4'd1, 32'h0, 4'd2, 32'hFFFF_FFFF, 32'h0, 32'h8000_0002, 1'b0, 2'b01, 4'h9);
    // R8: zero second specifier
    issue("R8 BALR r2=0", 3'd1, 4'd14, 32'h0, 4'd0, 32'h1234_5678, 32'h0, 32'h0000_4002, 1'b0, 2'b01, 4'h3);
    issue("R8 BASR r2=0", 3'd3, 4'd14, 32'h0, 4'd0, 32'h1234_5678, 32'h0, 32'h0000_4002, 1'b1, 2'b00, 4'h0);
    issue("R8 BASSM r2=0", 3'd4, 4'd14, 32'h0, 4'd0, 32'h8000_1000, 32'h0, 32'h0000_5002, 1'b0, 2'b00, 4'h0);
    issue("R8 BSM r2=0", 3'd5, 4'd5, 32'h7FFF_0000, 4'd0, 32'h8000_0000, 32'h0, 32'h0, 1'b1, 2'b00, 4'h0);
    // R7: BSM with nonzero first specifier
    issue("R7 BSM r1 narrow", 3'd5, 4'd5, 32'hFFFF_FFFF, 4'd6, 32'h0012_3400, 32'h0, 32'h0, 1'b0, 2'b00, 4'h0);
    issue("R7 BSM r1 wide", 3'd5, 4'd5, 32'h0000_0000, 4'd6, 32'h0012_3400, 32'h0, 32'h0, 1'b1, 2'b00, 4'h0);
    // R10: reserved codes
    issue("R10 code 6", 3'd6, 4'd14, 32'h1, 4'd15, 32'h2, 32'hFFFF_FFFF, 32'h3, 1'b1, 2'b11, 4'hF);
    issue("R10 code 7", 3'd7, 4'd14, 32'h1, 4'd15, 32'h2, 32'hFFFF_FFFF, 32'h3, 1'b0, 2'b11, 4'hF);

    // R6: four caller/callee pairs, return consumes the call's link word
    for (int k = 0; k < 4; k++) begin
      logic cm, sm;
      logic [31:0] callee;
      cm = k[1]; sm = k[0];
      callee = {sm, 31'h2345_6780 ^ {27'h0, k[3:0]}};
      issue("R6 BASSM call", 3'd4, 4'd14, 32'h0, 4'd15, callee, 32'h0, 32'h00A0_1000 + k * 2, cm, 2'b00, 4'h0);
      issue("R6 BSM return", 3'd5, 4'd0, 32'h0, 4'd14, last_link, 32'h0, 32'h0, sm, 2'b00, 4'h0);
    end
    in_valid = 0;
    repeat (4) @(negedge clk);
    n_run++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R10 drain: act %0d pending exp 0", sb.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule